// File: doc/BRIEF.md
# SPI flash command engine

This block is a register-mapped SPI master that runs a single flash command and then stops. Software programs a command opcode, a packed count byte and up to eight outgoing data bytes, then starts the engine. The engine asserts chip select, sends the opcode, then the outgoing data bytes, and then clocks in the requested number of reply bytes while driving zeros.

Outgoing and incoming data share one eight-entry buffer. Software reaches it through a single data port whose pointer steps forward on every access. Software can clear the pointer and read it back. Received bytes land in the buffer directly after the outgoing bytes. After a command, software clears the pointer, skips the bytes it sent and reads the reply. The serial clock runs in mode 0 and is derived from the system clock by a parameter that sets the half-period.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and the opcode (address 0), count (address 1), control (address 2) and status (address 3) registers all read 0.
- R2: A write to the data port (address 4) stores the byte at the entry the pointer selects. A read returns that entry. Each data-port access moves the pointer up by one, and the pointer wraps from 7 to 0. The pointer reads back in bits [2:0] of the status register.
- R3: Writing a control byte with bit 1 set returns the pointer to 0.
- R4: Writing a control byte with bit 0 set starts a command when the engine is idle. Control bit 0 and status bit 7 both read 1 while the command runs and return to 0 once chip select is released.
- R5: During one chip-select period, MOSI carries, most significant bit first: the opcode, then buffer entries 0 up to the outgoing count minus one, then one zero byte for each reply byte.
- R6: The count register holds the outgoing byte count in bits [3:0] and the reply byte count in bits [7:4]. An outgoing count above 8 is treated as 8.
- R7: With an outgoing count N greater than 0, reply byte k is stored in buffer entry N+k. Reply bytes that would fall past entry 7 are dropped.
- R8: With an outgoing count of 0, the first reply byte is discarded, and reply byte k (k of 1 or more) is stored in entry k-1.
- R9: The serial clock is low whenever chip select is high. The first rising clock edge comes exactly HALF_DIV system cycles after chip select falls, and chip select rises exactly HALF_DIV cycles after the last falling clock edge. MISO is sampled on rising edges.
- R10: While a command runs, writes to the opcode, count and data-port registers change nothing and do not move the pointer. Another start request also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; advances the pointer at the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, valid in the same cycle |
| spi_miso | input | 1 | Serial data from the flash |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
The hardest situation to reach is a bus access that lands in the middle of a running command. The ignored writes only show their effect after the command ends. The stimulus programs a command with two outgoing and fifteen reply bytes, which keeps the engine busy for several hundred cycles. It then issues opcode, count, data and start writes during that window. Afterwards it checks the registers, the pointer, the number of chip-select periods and the full buffer contents. A second hard case is the reply overflowing the buffer, together with the dummy slot when the outgoing count is zero. A table of commands covers both, and a flash model answers each one with bytes tagged by their position in the frame.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_SHIFT,
        SQ_TRAIL
    } seq_st_e;

    localparam logic [2:0] RA_OPCODE = 3'd0;
    localparam logic [2:0] RA_COUNT  = 3'd1;
    localparam logic [2:0] RA_CTRL   = 3'd2;
    localparam logic [2:0] RA_STATUS = 3'd3;
    localparam logic [2:0] RA_DATA   = 3'd4;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_CLR_BIT  = 1;
    localparam int STAT_BUSY_BIT = 7;

endpackage

// File: rtl/spi_eng_fifo.sv
// Shared data buffer: bus port through a wrapping pointer, engine port by index.
// DEPTH must be a power of two so the pointer wraps naturally.
module spi_eng_fifo #(
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [7:0]    bus_wdata,
    output logic [PW-1:0] ptr,
    output logic [7:0]    bus_rdata,
    input  logic [PW-1:0] eng_ridx,
    output logic [7:0]    eng_rdata,
    input  logic          eng_we,
    input  logic [PW-1:0] eng_widx,
    input  logic [7:0]    eng_wdata
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PW-1:0]         ptr;
    } fifo_s;

    fifo_s q, d;

    always_comb begin
        d = q;
        if (eng_we) d.mem[eng_widx] = eng_wdata;
        if (bus_we) d.mem[q.ptr] = bus_wdata;
        if (clr)                   d.ptr = '0;
        else if (bus_we || bus_re) d.ptr = q.ptr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ptr       = q.ptr;
    assign bus_rdata = q.mem[q.ptr];
    assign eng_rdata = q.mem[eng_ridx];

endmodule

// File: rtl/spi_eng_seq.sv
// Frame sequencer: chip select, mode-0 clock, shift registers, reply storage.
module spi_eng_seq
    import spi_eng_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int HALF_DIV = 2,
    parameter int PW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [PW:0]   tx_n,
    input  logic [3:0]    rx_n,
    output logic [PW-1:0] fifo_ridx,
    input  logic [7:0]    fifo_rdata,
    output logic          fifo_we,
    output logic [PW-1:0] fifo_widx,
    output logic [7:0]    fifo_wdata,
    output logic          busy,
    output logic          sck,
    output logic          cs_n,
    output logic          mosi,
    input  logic          miso
);

    localparam int DW   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BI_W = $clog2(DEPTH + 17);

    typedef struct packed {
        seq_st_e         st;
        logic [DW-1:0]   div;
        logic            sck;
        logic            cs_n;
        logic [7:0]      txsh;
        logic [7:0]      rxsh;
        logic [2:0]      bitn;
        logic [BI_W-1:0] bidx;
    } seq_s;

    seq_s q, d;

    logic            tick;
    logic [BI_W-1:0] last_idx;
    logic [BI_W-1:0] tx_w;
    logic [BI_W-1:0] sidx;
    logic            in_rx;
    logic            skip_dummy;

    always_comb begin
        tick       = (q.div == DW'(HALF_DIV - 1));
        tx_w       = BI_W'(tx_n);
        last_idx   = tx_w + BI_W'(rx_n);
        in_rx      = (q.bidx > tx_w);
        skip_dummy = (tx_n == '0) && (q.bidx == BI_W'(1));
        sidx       = (tx_n == '0) ? (q.bidx - BI_W'(2)) : (q.bidx - BI_W'(1));
        fifo_ridx  = q.bidx[PW-1:0];
        fifo_widx  = sidx[PW-1:0];
        fifo_wdata = q.rxsh;
        fifo_we    = 1'b0;

        d = q;
        if (q.st != SQ_IDLE) d.div = tick ? '0 : q.div + 1'b1;

        unique case (q.st)
            SQ_IDLE: begin
                d.div = '0;
                if (start) begin
                    d.st   = SQ_LEAD;
                    d.cs_n = 1'b0;
                    d.sck  = 1'b0;
                    d.txsh = opcode;
                    d.bitn = '0;
                    d.bidx = '0;
                end
            end
            SQ_LEAD: begin
                if (tick) begin
                    d.st   = SQ_SHIFT;
                    d.sck  = 1'b1;
                    d.rxsh = {q.rxsh[6:0], miso};
                end
            end
            SQ_SHIFT: begin
                if (tick) begin
                    if (!q.sck) begin
                        d.sck  = 1'b1;
                        d.rxsh = {q.rxsh[6:0], miso};
                    end else begin
                        d.sck = 1'b0;
                        if (q.bitn == 3'd7) begin
                            fifo_we = in_rx && !skip_dummy && (sidx < BI_W'(DEPTH));
                            if (q.bidx == last_idx) begin
                                d.st = SQ_TRAIL;
                            end else begin
                                d.bidx = q.bidx + 1'b1;
                                d.bitn = '0;
                                d.txsh = (q.bidx < tx_w) ? fifo_rdata : 8'h00;
                            end
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                            d.txsh = {q.txsh[6:0], 1'b0};
                        end
                    end
                end
            end
            SQ_TRAIL: begin
                if (tick) begin
                    d.cs_n = 1'b1;
                    d.st   = SQ_IDLE;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= SQ_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != SQ_IDLE);
    assign sck  = q.sck;
    assign cs_n = q.cs_n;
    assign mosi = q.txsh[7] & ~q.cs_n;

endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       spi_miso,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic       spi_mosi
);

    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [7:0] opc;
        logic [7:0] cnt;
    } regs_s;

    regs_s rf_q, rf_d;

    logic          eng_busy;
    logic          go;
    logic          ptr_clr;
    logic          fifo_bus_we;
    logic          fifo_bus_re;
    logic [PW-1:0] fifo_ptr;
    logic [7:0]    fifo_bus_rdata;
    logic [PW-1:0] eng_ridx;
    logic [7:0]    eng_rdata;
    logic          eng_we;
    logic [PW-1:0] eng_widx;
    logic [7:0]    eng_wdata;
    logic [PW:0]   tx_n;
    logic [7:0]    opc_cur;
    logic [7:0]    cnt_cur;

    always_comb begin
        rf_d = rf_q;
        if (bus_wr && !eng_busy && bus_addr == RA_OPCODE) rf_d.opc = bus_wdata;
        if (bus_wr && !eng_busy && bus_addr == RA_COUNT)  rf_d.cnt = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign opc_cur     = rf_q.opc;
    assign cnt_cur     = rf_q.cnt;
    assign go          = bus_wr && (bus_addr == RA_CTRL) && bus_wdata[CTRL_GO_BIT] && !eng_busy;
    assign ptr_clr     = bus_wr && (bus_addr == RA_CTRL) && bus_wdata[CTRL_CLR_BIT];
    assign fifo_bus_we = bus_wr && (bus_addr == RA_DATA) && !eng_busy;
    assign fifo_bus_re = bus_rd && (bus_addr == RA_DATA);

    always_comb begin
        if (32'(rf_q.cnt[3:0]) > DEPTH) tx_n = (PW+1)'(DEPTH);
        else                            tx_n = (PW+1)'(rf_q.cnt[3:0]);
    end

    always_comb begin
        unique case (bus_addr)
            RA_OPCODE: bus_rdata = rf_q.opc;
            RA_COUNT:  bus_rdata = rf_q.cnt;
            RA_CTRL:   bus_rdata = {7'b0, eng_busy};
            RA_STATUS: bus_rdata = {eng_busy, {(7-PW){1'b0}}, fifo_ptr};
            RA_DATA:   bus_rdata = fifo_bus_rdata;
            default:   bus_rdata = 8'h00;
        endcase
    end

    spi_eng_fifo #(.DEPTH(DEPTH), .PW(PW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ptr_clr),
        .bus_we    (fifo_bus_we),
        .bus_re    (fifo_bus_re),
        .bus_wdata (bus_wdata),
        .ptr       (fifo_ptr),
        .bus_rdata (fifo_bus_rdata),
        .eng_ridx  (eng_ridx),
        .eng_rdata (eng_rdata),
        .eng_we    (eng_we),
        .eng_widx  (eng_widx),
        .eng_wdata (eng_wdata)
    );

    spi_eng_seq #(.DEPTH(DEPTH), .HALF_DIV(HALF_DIV), .PW(PW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (go),
        .opcode     (rf_q.opc),
        .tx_n       (tx_n),
        .rx_n       (rf_q.cnt[7:4]),
        .fifo_ridx  (eng_ridx),
        .fifo_rdata (eng_rdata),
        .fifo_we    (eng_we),
        .fifo_widx  (eng_widx),
        .fifo_wdata (eng_wdata),
        .busy       (eng_busy),
        .sck        (spi_sck),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .miso       (spi_miso)
    );

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk
    import spi_eng_pkg::*;
#(
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [7:0]    bus_wdata,
    input logic          busy,
    input logic [PW-1:0] ptr,
    input logic [7:0]    opc,
    input logic [7:0]    cnt,
    input logic          sck,
    input logic          cs_n
);

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R9

    AST_CS_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(!sck)); // R9

    AST_CS_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy); // R4

    AST_OPC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(opc)); // R10

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cnt)); // R10

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_wr && !bus_rd && bus_addr == RA_DATA) |=> ptr == PW'($past(ptr) + 1'b1)); // R2

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_CTRL && bus_wdata[CTRL_CLR_BIT]) |=> ptr == '0); // R3

    AST_BUSY_DATA_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && !bus_rd && bus_addr == RA_DATA) |=> $stable(ptr)); // R10

endmodule

bind spi_flash_cmd_engine spi_eng_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .busy      (eng_busy),
    .ptr       (fifo_ptr),
    .opc       (opc_cur),
    .cnt       (cnt_cur),
    .sck       (spi_sck),
    .cs_n      (spi_cs_n)
);

// File: tb/spi_flash_cmd_engine_test.sv
`timescale 1ns/1ps
module spi_flash_cmd_engine_test;

    localparam int HALF_DIV = 2;
    localparam int DEPTH    = 8;
    localparam int NVEC     = 6;
    // {opcode, count byte, seed}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h9F, 8'h40, 8'h11},   // tx0 rx4: dummy slot, R8
        {8'h03, 8'h43, 8'h22},   // tx3 rx4
        {8'h0B, 8'h64, 8'h33},   // tx4 rx6: overflow drop, R7
        {8'h02, 8'h08, 8'h44},   // tx8 rx0
        {8'h05, 8'h10, 8'h55},   // tx0 rx1: only dummy
        {8'h5A, 8'h1C, 8'h66}    // tx12 clamped to 8, R6
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_miso = 1'b0;
    logic       spi_sck;
    logic       spi_cs_n;
    logic       spi_mosi;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    spi_flash_cmd_engine #(.DEPTH(DEPTH), .HALF_DIV(HALF_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_miso(spi_miso), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi)
    );

    // Flash model
    logic [7:0] cur_seed = '0;
    logic [7:0] cap [32];
    logic [7:0] shreg = '0;
    int   nbits = 0;
    int   frames = 0;
    int   lead_cyc = 0;
    int   trail_cyc = 0;
    time  t_csfall = 0;
    time  t_lastfall = 0;
    logic first_rise = 1'b0;
    logic cs_prev = 1'b1;
    logic sck_prev = 1'b0;
    logic [7:0] mirror [DEPTH];

    function automatic logic [7:0] resp_b(input int j, input logic [7:0] seed);
        return seed ^ (8'(j) * 8'd37) ^ 8'hC3;
    endfunction

    function automatic logic [7:0] txd(input int i, input logic [7:0] seed);
        return seed + 8'(i) * 8'd17;
    endfunction

    always @(spi_sck or spi_cs_n) begin
        if (spi_cs_n !== cs_prev) begin
            cs_prev = spi_cs_n;
            if (spi_cs_n === 1'b0) begin
                nbits = 0;
                frames++;
                first_rise = 1'b1;
                t_csfall = $time;
                spi_miso = resp_b(0, cur_seed)[7];
            end else begin
                trail_cyc = int'(($time - t_lastfall) / 8);
            end
        end
        if (spi_sck !== sck_prev) begin
            sck_prev = spi_sck;
            if (spi_cs_n === 1'b0) begin
                if (spi_sck) begin
                    if (first_rise) begin
                        lead_cyc = int'(($time - t_csfall) / 8);
                        first_rise = 1'b0;
                    end
                    shreg = {shreg[6:0], spi_mosi};
                    if (nbits % 8 == 7 && nbits / 8 < 32) cap[nbits / 8] = shreg;
                    nbits++;
                end else begin
                    t_lastfall = $time;
                    spi_miso = resp_b(nbits / 8, cur_seed)[7 - (nbits % 8)];
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] dv);
        @(negedge clk);
        bus_addr = a; bus_wdata = dv; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] dv);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 dv = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        int n = 0;
        do begin
            rd(3'd3, s);
            n++;
        end while (s[7] && n < 5000);
    endtask

    task automatic check_buffer(input string req);
        logic [7:0] v;
        wr(3'd2, 8'h02);
        for (int i = 0; i < DEPTH; i++) begin
            rd(3'd4, v);
            chk(req, {24'h0, v}, {24'h0, mirror[i]});
        end
    endtask

    initial begin
        #1200000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) mirror[i] = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 cs_n", {31'h0, spi_cs_n}, 32'h1);
        chk("R1 sck", {31'h0, spi_sck}, 32'h0);
        rst_n = 1'b1;
        rd(3'd0, v); chk("R1 opcode", {24'h0, v}, 32'h0);
        rd(3'd1, v); chk("R1 count", {24'h0, v}, 32'h0);
        rd(3'd2, v); chk("R1 control", {24'h0, v}, 32'h0);
        rd(3'd3, v); chk("R1 status", {24'h0, v}, 32'h0);

        // Table-driven commands
        for (int vi = 0; vi < NVEC; vi++) begin
            logic [7:0] opc, cnt, seed;
            int tx, rx, fr0;
            {opc, cnt, seed} = VEC[vi];
            tx = (int'(cnt[3:0]) > DEPTH) ? DEPTH : int'(cnt[3:0]);
            rx = int'(cnt[7:4]);
            cur_seed = seed;
            wr(3'd2, 8'h02);
            wr(3'd0, opc);
            wr(3'd1, cnt);
            for (int i = 0; i < tx; i++) begin
                wr(3'd4, txd(i, seed));
                mirror[i] = txd(i, seed);
            end
            rd(3'd3, v);
            chk("R2 pointer after loads", {29'h0, v[2:0]}, 32'(tx % DEPTH));
            wr(3'd2, 8'h02);
            rd(3'd3, v);
            chk("R3 pointer cleared", {29'h0, v[2:0]}, 32'h0);
            fr0 = frames;
            wr(3'd2, 8'h01);
            rd(3'd2, v);
            chk("R4 control busy", {24'h0, v}, 32'h1);
            rd(3'd3, v);
            chk("R4 status busy", {31'h0, v[7]}, 32'h1);
            wait_idle();
            rd(3'd2, v);
            chk("R4 control cleared", {24'h0, v}, 32'h0);
            chk("R5 one frame", 32'(frames - fr0), 32'h1);
            chk("R5 bit count", 32'(nbits), 32'(8 * (1 + tx + rx)));
            chk("R5 opcode first", {24'h0, cap[0]}, {24'h0, opc});
            for (int i = 0; i < tx; i++)
                chk("R5 outgoing byte", {24'h0, cap[1 + i]}, {24'h0, txd(i, seed)});
            for (int k = 0; k < rx; k++)
                chk("R5 zero filler", {24'h0, cap[1 + tx + k]}, 32'h0);
            chk("R9 lead", 32'(lead_cyc), 32'(HALF_DIV));
            chk("R9 trail", 32'(trail_cyc), 32'(HALF_DIV));
            for (int k = 0; k < rx; k++) begin
                int j, idx;
                j = 1 + tx + k;
                idx = (tx == 0) ? j - 2 : j - 1;
                if (!(tx == 0 && k == 0) && idx < DEPTH) mirror[idx] = resp_b(j, seed);
            end
            check_buffer((tx == 0) ? "R8 buffer" : ((vi == 5) ? "R6 buffer" : "R7 buffer"));
        end

        // R2: pointer wraps from 7 to 0 on reads
        wr(3'd2, 8'h02);
        for (int i = 0; i < 9; i++) rd(3'd4, v);
        rd(3'd3, v);
        chk("R2 pointer wrap", {29'h0, v[2:0]}, 32'h1);

        // R10: accesses during a long command
        begin
            int fr0;
            cur_seed = 8'h77;
            wr(3'd2, 8'h02);
            wr(3'd0, 8'hAB);
            wr(3'd1, 8'hF2);
            wr(3'd4, txd(0, 8'h77)); mirror[0] = txd(0, 8'h77);
            wr(3'd4, txd(1, 8'h77)); mirror[1] = txd(1, 8'h77);
            fr0 = frames;
            wr(3'd2, 8'h01);
            wr(3'd0, 8'hEE);
            wr(3'd1, 8'h00);
            wr(3'd4, 8'h55);
            wr(3'd2, 8'h01);
            wait_idle();
            repeat (20) @(negedge clk);
            rd(3'd0, v); chk("R10 opcode kept", {24'h0, v}, 32'hAB);
            rd(3'd1, v); chk("R10 count kept", {24'h0, v}, 32'hF2);
            rd(3'd3, v); chk("R10 pointer kept", {24'h0, v}, 32'h2);
            chk("R10 single frame", 32'(frames - fr0), 32'h1);
            chk("R10 frame length", 32'(nbits), 32'(8 * 18));
            for (int k = 0; k < 15; k++)
                if (2 + k < DEPTH) mirror[2 + k] = resp_b(3 + k, 8'h77);
            check_buffer("R10 buffer");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule